// File: doc/BRIEF.md
# Dual DAC Serial Command Interface

This block is the digital front end of a two-channel 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port with three signals: an active-low chip select, a serial clock and a data line. The block decodes each word and updates one of several targets: a holding buffer, the channel A code latch, the channel B code latch or a small control register. It drives the two 10-bit codes, a 2-bit reference selection, a fast/slow speed flag and a power-down flag to the analog section.

The serial signals are asynchronous to the block's system clock. Each one passes through a synchronizer and is edge-detected in the system clock domain. A word is committed after its sixteenth bit. If chip select rises before sixteen bits have arrived, the partial word is committed at that moment instead. Routing a code through the holding buffer lets the host prepare channel B first and then change both channel outputs in the same cycle.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: After reset, both codes, the holding buffer, the reference selection, the speed flag and the power-down flag are all zero.
- R2: A falling chip select opens a frame. Data is taken most significant bit first on each falling serial-clock edge. After the sixteenth bit the word is committed, and the outputs reflect it while chip select is still low.
- R3: Word layout: bit 15 is the upper select bit, bit 14 the speed bit, bit 13 the power bit, bit 12 the lower select bit. For code writes the 10-bit code is bits 11..2, and bits 1..0 have no effect.
- R4: Select value 00 ({bit15,bit12}) writes the code into both the channel B latch and the holding buffer. Channel A is unchanged.
- R5: Select value 01 writes only the holding buffer. Both output codes stay unchanged.
- R6: Select value 10 writes the code into channel A. In the same cycle it copies the holding buffer into channel B.
- R7: Select value 11 loads the reference selection from bits 1..0. All other data bits are ignored, and both codes and the buffer stay unchanged.
- R8: The speed flag is taken from bit 14 (1 = fast) and the power-down flag from bit 13 (1 = powered down) of every committed word, whatever its select value.
- R9: If chip select rises after n bits, with 1 ≤ n ≤ 15, the committed word holds the n received bits in its low n positions, and its upper positions are zero. A chip-select pulse with no clock edges commits nothing.
- R10: Serial-clock edges while chip select is high are ignored. So are any edges after the sixteenth bit of a frame, until a new frame opens.
- R11: The reference selection passes all four codes through unchanged: 00 and 11 mean external, 01 means the lower internal level and 10 the higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data sampled on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| code_a_o | output | 10 | Channel A code |
| code_b_o | output | 10 | Channel B code |
| ref_sel_o | output | 2 | Reference source and level selection |
| fast_mode_o | output | 1 | 1 = fast settling mode, 0 = slow |
| power_down_o | output | 1 | 1 = analog section powered down |

## Verification
The bench drives one word for each of the four select values.

- The simultaneous A/B update is checked with a buffer value that differs from the new channel A code. A design that loaded channel B from the incoming data, or one cycle late, would show the wrong channel B value.
- Early chip-select termination is checked at several bit counts. A design that committed a stale or left-aligned shift register, or that waited for sixteen bits, would show wrong codes.
- Extra clock edges after the sixteenth bit, and clock edges with chip select high, are sent with random data. A design that kept shifting would corrupt the committed values at the next chip-select rise.
- Control words that carry nonzero code bits expose any leak of those bits into the code latches.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int WORD_W    = 16;
  localparam int CODE_W    = 10;
  localparam int POS_SEL_HI = 15;
  localparam int POS_SPEED  = 14;
  localparam int POS_PWR    = 13;
  localparam int POS_SEL_LO = 12;
  localparam int DATA_TOP   = 11;
  localparam int REF_W      = 2;

  typedef enum logic [1:0] {
    SEL_B_AND_BUF = 2'b00,
    SEL_BUF_ONLY  = 2'b01,
    SEL_A_XFER_B  = 2'b10,
    SEL_CTRL      = 2'b11
  } dac_sel_e;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic out_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], in_i};
  end

  assign out_o = chain_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              cs_q, sclk_q, open_q, open_d, commit_q, commit_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, word_q, word_d;
  logic              cs_fall, cs_rise, sclk_fall;

  assign cs_fall   = cs_q & ~cs_s_i;
  assign cs_rise   = ~cs_q & cs_s_i;
  assign sclk_fall = sclk_q & ~sclk_s_i;

  always_comb begin
    open_d   = open_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    word_d   = word_q;
    commit_d = 1'b0;
    if (cs_fall) begin
      open_d = 1'b1;
      cnt_d  = '0;
      sh_d   = '0;
    end else if (cs_rise) begin
      open_d = 1'b0;
      if (open_q && cnt_q != '0 && cnt_q != CNT_FULL) begin
        commit_d = 1'b1;
        word_d   = sh_q;
      end
    end else if (open_q && sclk_fall && cnt_q != CNT_FULL) begin
      sh_d  = {sh_q[WORD_W-2:0], sdi_s_i};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_FULL - CNT_W'(1)) begin
        commit_d = 1'b1;
        word_d   = sh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      open_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      word_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      cs_q     <= cs_s_i;
      sclk_q   <= sclk_s_i;
      open_q   <= open_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      word_q   <= word_d;
      commit_q <= commit_d;
    end
  end

  assign commit_o = commit_q;
  assign word_o   = word_q;

  // R10: the bit count never runs past a full word
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R10: clock edges outside an open frame leave the count alone
  a_r10_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && sclk_s_i == 1'b0 && sclk_q && cs_s_i && cs_q) |=> $stable(cnt_q));
  // R9: a commit only follows a frame that received bits
  a_r9_commit_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(cnt_q) != '0);
endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              fast_mode_o,
  output logic              power_down_o
);
  localparam int DATA_LOW = DATA_TOP - CODE_W + 1;

  logic [CODE_W-1:0] a_q, a_d, b_q, b_d, buf_q, buf_d, new_code;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              fast_q, fast_d, pd_q, pd_d;
  dac_sel_e          sel;

  assign new_code = word_i[DATA_TOP:DATA_LOW];
  assign sel      = dac_sel_e'({word_i[POS_SEL_HI], word_i[POS_SEL_LO]});

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    buf_d  = buf_q;
    ref_d  = ref_q;
    fast_d = fast_q;
    pd_d   = pd_q;
    if (commit_i) begin
      fast_d = word_i[POS_SPEED];
      pd_d   = word_i[POS_PWR];
      unique case (sel)
        SEL_B_AND_BUF: begin b_d = new_code; buf_d = new_code; end
        SEL_BUF_ONLY:  buf_d = new_code;
        SEL_A_XFER_B:  begin a_d = new_code; b_d = buf_q; end
        SEL_CTRL:      ref_d = word_i[REF_W-1:0];
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; buf_q <= '0; ref_q <= '0; fast_q <= 1'b0; pd_q <= 1'b0;
    end else begin
      a_q <= a_d; b_q <= b_d; buf_q <= buf_d; ref_q <= ref_d; fast_q <= fast_d; pd_q <= pd_d;
    end
  end

  assign code_a_o     = a_q;
  assign code_b_o     = b_q;
  assign ref_sel_o    = ref_q;
  assign fast_mode_o  = fast_q;
  assign power_down_o = pd_q;

  // R2: outputs move only on a committed word
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(ref_sel_o)
                   && $stable(fast_mode_o) && $stable(power_down_o)));
  // R5: a buffer-only write leaves both codes alone
  a_r5_buf_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sel == SEL_BUF_ONLY) |=> ($stable(code_a_o) && $stable(code_b_o)));
  // R6: channel B takes the buffer content on the transfer write
  a_r6_b_from_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sel == SEL_A_XFER_B) |=> code_b_o == $past(buf_q));
  // R7: a control write leaves both codes alone
  a_r7_ctrl_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sel == SEL_CTRL) |=> ($stable(code_a_o) && $stable(code_b_o)));
endmodule

// File: rtl/dual_dac_cmd_if.sv
module dual_dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              fast_mode_o,
  output logic              power_down_o
);
  logic cs_s, sclk_s, sdi_s, commit;
  logic [WORD_W-1:0] word;

  dac_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .in_i(cs_n_i), .out_o(cs_s));
  dac_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .in_i(sclk_i), .out_o(sclk_s));
  dac_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .in_i(sdi_i), .out_o(sdi_s));

  dac_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s_i(cs_s), .sclk_s_i(sclk_s), .sdi_s_i(sdi_s),
    .commit_o(commit), .word_o(word));

  dac_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .word_i(word),
    .code_a_o(code_a_o), .code_b_o(code_b_o), .ref_sel_o(ref_sel_o),
    .fast_mode_o(fast_mode_o), .power_down_o(power_down_o));
endmodule

// File: tb/dual_dac_cmd_if_tb.sv
module dual_dac_cmd_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] code_a, code_b;
  logic [1:0] ref_sel;
  logic fast, pd;
  int n_tests = 0, n_fail = 0;

  logic [9:0] m_a = '0, m_b = '0, m_buf = '0;
  logic [1:0] m_ref = '0;
  logic m_fast = 1'b0, m_pd = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .ref_sel_o(ref_sel),
    .fast_mode_o(fast), .power_down_o(pd));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " code_a"}, 16'(code_a), 16'(m_a));
    chk({req, " code_b"}, 16'(code_b), 16'(m_b));
    chk({req, " ref_sel"}, 16'(ref_sel), 16'(m_ref));
    chk({req, " fast"}, 16'(fast), 16'(m_fast));
    chk({req, " power_down"}, 16'(pd), 16'(m_pd));
  endtask

  function automatic void model(input logic [15:0] w);
    logic [9:0] c;
    c = w[11:2];
    m_fast = w[14];
    m_pd   = w[13];
    case ({w[15], w[12]})
      2'b00: begin m_b = c; m_buf = c; end
      2'b01: m_buf = c;
      2'b10: begin m_a = c; m_b = m_buf; end
      default: m_ref = w[1:0];
    endcase
  endfunction

  // Opens a frame and clocks n data bits (MSB first) plus extra random bits; leaves cs low.
  task automatic shift_bits(input logic [15:0] w, input int n, input int extra);
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n + extra; i++) begin
      sdi  = (i < n) ? w[15 - i] : 1'($urandom);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic full_word(input logic [15:0] w, input string req);
    shift_bits(w, 16, 0);
    model(w);
    check_all(req);          // updated while cs still low
    close_frame();
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // R4: select 00, bits 1..0 set to show they are ignored (R3)
    full_word({1'b0, 1'b1, 1'b0, 1'b0, 10'h2A5, 2'b11}, "R4 R3");
    // R5: buffer only
    full_word({1'b0, 1'b0, 1'b0, 1'b1, 10'h133, 2'b10}, "R5");
    // R6: A write with B loaded from buffer simultaneously
    full_word({1'b1, 1'b1, 1'b0, 1'b0, 10'h3C1, 2'b01}, "R6");
    chk("R6 b equals buffer", 16'(code_b), 16'h0133);
    // R7 / R11: control writes with noisy data bits, all four reference codes
    for (int r = 0; r < 4; r++)
      full_word({1'b1, 1'b0, 1'b0, 1'b1, 10'h3FF, 2'(r)}, "R7 R11");
    // R8: power-down via a buffer write, then via a control write
    full_word({1'b0, 1'b1, 1'b1, 1'b1, 10'h055, 2'b00}, "R8 pd");
    full_word({1'b1, 1'b0, 1'b0, 1'b1, 10'h000, 2'b10}, "R8 wake");

    // R9: early termination at several lengths
    foreach (w[k]) begin end
    for (int n = 1; n < 16; n += 3) begin
      logic [15:0] part;
      w = 16'($urandom);
      shift_bits(w, n, 0);
      close_frame();
      part = w >> (16 - n);
      model(part);
      check_all("R9 early");
    end
    // R9: chip-select pulse with no clocks
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    close_frame();
    check_all("R9 empty");

    // R10: clocks while chip select is high
    for (int i = 0; i < 20; i++) begin
      sdi = 1'($urandom); sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    check_all("R10 cs high");
    // R10: extra clocks after the sixteenth bit
    w = {1'b0, 1'b0, 1'b0, 1'b0, 10'h0F0, 2'b00};
    shift_bits(w, 16, 7);
    model(w);
    close_frame();
    check_all("R10 extra");
    full_word({1'b1, 1'b1, 1'b0, 1'b0, 10'h00F, 2'b00}, "R10 next frame");

    // R2: random full frames
    for (int i = 0; i < 40; i++) full_word(16'($urandom), "R2 random");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule